// File: doc/BRIEF.md
# Serial Flash Operation Phase Sequencer

This block runs one serial-flash style operation at a time. A host presents a configuration word, a packet length and a packet count, then pulses a start input. The sequencer lowers chip select and walks the operation through up to three phases. The first is an opcode phase on a single line. The second is a combined address-plus-dummy phase. The third is an optional data phase. The data phase is half-duplex: it either sends bytes taken from a transmit byte stream or fills a receive byte stream from the IO lines.

The serial clock follows mode 0. It idles low, and each pulse on the tick input toggles it once, so the tick rate sets the bus speed. Output bits change only while the clock is low. Input bits are captured on the rising clock edge. The IO lines are described as separate output-value, output-enable and input vectors, so that pad logic outside the block can build the bidirectional pins. Opcode, address and dummy bytes all come from the transmit stream in the order they go on the wire. The host therefore places the address most significant byte first and supplies 0xFF for each dummy byte.

Top module: `qspi_phase_seq`

## Requirements
- R1: While reset is held and after it is released, chip select (`cs_n_o`) is high, `sck_o` is low, all `io_oe_o` bits are 0, and `done_o` and `tx_ready_o` are 0.
- R2: Configuration bits 11:8 give the number of opcode bytes. These bytes are sent first, one line wide on IO0, most significant bit first, with `io_oe_o` equal to 4'b0001. A count of 0 skips the phase.
- R3: Configuration bits 15:12 give the combined address-plus-dummy byte count. These bytes follow the opcode bytes. They are one line wide when bit 4 (the wide-mode flag) is 1, and use the pin-mode width otherwise. A count of 0 skips the phase.
- R4: Pin mode, bits 1:0, sets the data width. A value of 0 uses one line (IO0 out, IO1 in). A value of 1 uses two lines, with IO1 carrying the more significant bit of each pair. A value of 2 or 3 uses four lines, with IO3..IO0 carrying bits 7:4 and then bits 3:0. Bits always go out most significant first.
- R5: With direction bit 2 set to 1, the data phase receives. All `io_oe_o` bits are 0, bits are captured on each rising `sck_o`, and each assembled byte appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse.
- R6: With direction bit 2 set to 0, the data phase transmits bytes taken from the stream by the `tx_valid_i`/`tx_ready_o` handshake, using the pin-mode width and output enables.
- R7: When bit 5 (the no-data flag) is 1, the data phase is skipped and the operation ends after the last address-plus-dummy byte.
- R8: The data phase moves (`pkt_len_m1_i`+1) × (`pkt_cnt_m1_i`+1) bytes, that is, that many packets chained back to back with no gap.
- R9: `sck_o` is low whenever `cs_n_o` is high. `io_out_o` does not change while `sck_o` is high. Each `sck_tick_i` pulse in a shifting cycle toggles `sck_o` once.
- R10: When a transmit byte is needed and `tx_valid_i` is low, `tx_ready_o` stays high and `sck_o` holds low until a byte is accepted.
- R11: `done_o` pulses high for exactly one cycle, in the cycle after the last falling `sck_o` edge, with `cs_n_o` already high. An operation with no bytes at all finishes with no clock edges.
- R12: A start pulse while an operation is in progress is ignored, and so are configuration changes made during it.
- R13: A start pulse is accepted only when bit 3 (half-duplex enable) is 1 and bits 7:6 are 0. Otherwise nothing happens and chip select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one operation when idle |
| cfg_i | input | 16 | Operation configuration word |
| pkt_len_m1_i | input | PKT_W | Bytes per data packet minus one |
| pkt_cnt_m1_i | input | LOOP_W | Number of data packets minus one |
| sck_tick_i | input | 1 | Half-period tick of the serial clock |
| tx_data_i | input | 8 | Transmit stream byte |
| tx_valid_i | input | 1 | Transmit byte available |
| tx_ready_o | output | 1 | Sequencer takes a byte this cycle if valid |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| io_out_o | output | 4 | IO output values |
| io_oe_o | output | 4 | IO output enables |
| io_in_i | input | 4 | IO input values |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| done_o | output | 1 | Operation finished pulse |

## Verification
Some properties are checked on every cycle by the assertions. The clock stays low while deselected. The IO output values stay frozen through every high clock half. A stalled transmit request holds until it is served. Done is a lone pulse with the clock low. Receive strobes arrive only with every output enable released. Other behaviour can only be shown by the bench scenarios. These are the exact bit stream and enable pattern on each lane for each phase layout, the packet-times-count byte total, no-data and empty operations, rejected starts, and start pulses during a busy operation. The bench compares these slot by slot at every rising clock against a model of the wire format.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_END} seq_state_e;
  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DAT, PH_FIN} seq_phase_e;

  typedef struct packed {
    logic [3:0] adr_n;
    logic [3:0] opc_n;
    logic       nodata;
    logic       wide;
    logic       rx_dir;
    logic [1:0] pmode;
  } op_cfg_t;

  function automatic op_cfg_t unpack_cfg(input logic [15:0] w);
    op_cfg_t c;
    c.pmode  = w[1:0];
    c.rx_dir = w[2];
    c.wide   = w[4];
    c.nodata = w[5];
    c.opc_n  = w[11:8];
    c.adr_n  = w[15:12];
    return c;
  endfunction

  function automatic logic [2:0] mode_lanes(input logic [1:0] m);
    case (m)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] last_slot(input logic [2:0] lanes);
    case (lanes)
      3'd1:    return 3'd7;
      3'd2:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  function automatic seq_phase_e phase_after(input op_cfg_t c, input seq_phase_e from);
    seq_phase_e r;
    r = PH_FIN;
    if (from == PH_FIN && c.opc_n != 4'd0)
      r = PH_OPC;
    else if ((from == PH_FIN || from == PH_OPC) && c.adr_n != 4'd0)
      r = PH_ADR;
    else if (from != PH_DAT && !c.nodata)
      r = PH_DAT;
    return r;
  endfunction

endpackage

// File: rtl/qspi_lane_shift.sv
module qspi_lane_shift
  import qspi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       shift_i,
  input  logic       sample_i,
  input  logic [2:0] lanes_i,
  input  logic [3:0] io_in_i,
  output logic [3:0] bits_o,
  output logic [7:0] rx_byte_o
);

  logic [7:0] tx_q, tx_d;
  logic [7:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i) begin
      tx_d = byte_i;
    end else if (shift_i) begin
      case (lanes_i)
        3'd1:    tx_d = {tx_q[6:0], 1'b0};
        3'd2:    tx_d = {tx_q[5:0], 2'b00};
        default: tx_d = {tx_q[3:0], 4'b0000};
      endcase
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (sample_i) begin
      case (lanes_i)
        3'd1:    rx_d = {rx_q[6:0], io_in_i[1]};
        3'd2:    rx_d = {rx_q[5:0], io_in_i[1:0]};
        default: rx_d = {rx_q[3:0], io_in_i[3:0]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 8'h00;
      rx_q <= 8'h00;
    end else begin
      if (load_i || shift_i) tx_q <= tx_d;
      if (sample_i)          rx_q <= rx_d;
    end
  end

  always_comb begin
    case (lanes_i)
      3'd1:    bits_o = {3'b000, tx_q[7]};
      3'd2:    bits_o = {2'b00, tx_q[7:6]};
      default: bits_o = tx_q[7:4];
    endcase
  end

  assign rx_byte_o = rx_q;

  assert_no_load_while_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !(shift_i || sample_i));

endmodule

// File: rtl/qspi_seq_ctrl.sv
module qspi_seq_ctrl
  import qspi_seq_pkg::*;
#(
  parameter int PKT_W  = 16,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       cfg_i,
  input  logic [PKT_W-1:0]  pkt_len_m1_i,
  input  logic [LOOP_W-1:0] pkt_cnt_m1_i,
  input  logic              tick_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              load_o,
  output logic              shift_o,
  output logic              sample_o,
  output logic [2:0]        lanes_o,
  output logic              drive_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              done_o,
  output logic              rx_valid_o
);

  seq_state_e        st_q, st_d;
  seq_phase_e        ph_q, ph_d;
  op_cfg_t           cfg_q, cfg_d, cfg_in;
  logic [3:0]        hdr_q, hdr_d;
  logic [PKT_W-1:0]  len_q, len_d, bcnt_q, bcnt_d;
  logic [LOOP_W-1:0] pcnt_q, pcnt_d;
  logic [2:0]        slot_q, slot_d;
  logic              sck_q, sck_d;
  logic              rxv_q, rxv_d;
  logic              accept, rx_phase, need_tx, rise_ev, fall_ev;

  assign cfg_in   = unpack_cfg(cfg_i);
  assign accept   = start_i && cfg_i[3] && (cfg_i[7:6] == 2'b00);
  assign rx_phase = (ph_q == PH_DAT) && cfg_q.rx_dir;
  assign need_tx  = !rx_phase;
  assign rise_ev  = (st_q == ST_SHIFT) && tick_i && !sck_q;
  assign fall_ev  = (st_q == ST_SHIFT) && tick_i && sck_q;

  always_comb begin
    case (ph_q)
      PH_OPC:  lanes_o = 3'd1;
      PH_ADR:  lanes_o = cfg_q.wide ? 3'd1 : mode_lanes(cfg_q.pmode);
      default: lanes_o = mode_lanes(cfg_q.pmode);
    endcase
  end

  assign tx_ready_o = (st_q == ST_LOAD) && need_tx;
  assign load_o     = tx_ready_o && tx_valid_i;
  assign shift_o    = fall_ev && (slot_q != 3'd0);
  assign sample_o   = rise_ev;
  assign drive_o    = ((st_q == ST_LOAD) || (st_q == ST_SHIFT)) && need_tx;
  assign sck_o      = sck_q;
  assign cs_n_o     = (st_q == ST_IDLE) || (st_q == ST_END);
  assign done_o     = (st_q == ST_END);
  assign rx_valid_o = rxv_q;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    cfg_d  = cfg_q;
    hdr_d  = hdr_q;
    len_d  = len_q;
    bcnt_d = bcnt_q;
    pcnt_d = pcnt_q;
    slot_d = slot_q;
    sck_d  = sck_q;
    rxv_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cfg_d  = cfg_in;
          len_d  = pkt_len_m1_i;
          bcnt_d = pkt_len_m1_i;
          pcnt_d = pkt_cnt_m1_i;
          ph_d   = phase_after(cfg_in, PH_FIN);
          hdr_d  = (ph_d == PH_OPC) ? cfg_in.opc_n : cfg_in.adr_n;
          st_d   = (ph_d == PH_FIN) ? ST_END : ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (!need_tx || tx_valid_i) begin
          st_d   = ST_SHIFT;
          slot_d = last_slot(lanes_o);
        end
      end
      ST_SHIFT: begin
        if (rise_ev) sck_d = 1'b1;
        if (fall_ev) begin
          sck_d = 1'b0;
          if (slot_q != 3'd0) begin
            slot_d = slot_q - 3'd1;
          end else begin
            if (ph_q == PH_DAT) begin
              rxv_d = cfg_q.rx_dir;
              if (bcnt_q == '0) begin
                if (pcnt_q == '0) begin
                  ph_d = PH_FIN;
                end else begin
                  pcnt_d = pcnt_q - 1'b1;
                  bcnt_d = len_q;
                end
              end else begin
                bcnt_d = bcnt_q - 1'b1;
              end
            end else if (hdr_q == 4'd1) begin
              ph_d  = phase_after(cfg_q, ph_q);
              hdr_d = cfg_q.adr_n;
            end else begin
              hdr_d = hdr_q - 4'd1;
            end
            st_d = (ph_d == PH_FIN) ? ST_END : ST_LOAD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_FIN;
      cfg_q  <= '0;
      hdr_q  <= '0;
      len_q  <= '0;
      bcnt_q <= '0;
      pcnt_q <= '0;
      slot_q <= '0;
      sck_q  <= 1'b0;
      rxv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cfg_q  <= cfg_d;
      hdr_q  <= hdr_d;
      len_q  <= len_d;
      bcnt_q <= bcnt_d;
      pcnt_q <= pcnt_d;
      slot_q <= slot_d;
      sck_q  <= sck_d;
      rxv_q  <= rxv_d;
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && !tx_valid_i) |=> (tx_ready_o && !sck_q));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_sck_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sck_q);

  assert_rx_strobe_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |-> (cfg_q.rx_dir && !cfg_q.nodata));

endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
  import qspi_seq_pkg::*;
#(
  parameter int PKT_W  = 16,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       cfg_i,
  input  logic [PKT_W-1:0]  pkt_len_m1_i,
  input  logic [LOOP_W-1:0] pkt_cnt_m1_i,
  input  logic              sck_tick_i,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o,
  output logic [3:0]        io_out_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_in_i,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              done_o
);

  localparam int NLANE = 4;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       load, shift, sample, drive;
  logic [2:0] lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  qspi_seq_ctrl #(.PKT_W(PKT_W), .LOOP_W(LOOP_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_i      (start_i),
    .cfg_i        (cfg_i),
    .pkt_len_m1_i (pkt_len_m1_i),
    .pkt_cnt_m1_i (pkt_cnt_m1_i),
    .tick_i       (sck_tick_i),
    .tx_valid_i   (tx_valid_i),
    .tx_ready_o   (tx_ready_o),
    .load_o       (load),
    .shift_o      (shift),
    .sample_o     (sample),
    .lanes_o      (lanes),
    .drive_o      (drive),
    .sck_o        (sck_o),
    .cs_n_o       (cs_n_o),
    .done_o       (done_o),
    .rx_valid_o   (rx_valid_o)
  );

  qspi_lane_shift shift_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_i    (load),
    .byte_i    (tx_data_i),
    .shift_i   (shift),
    .sample_i  (sample),
    .lanes_i   (lanes),
    .io_in_i   (io_in_i),
    .bits_o    (io_out_o),
    .rx_byte_o (rx_data_o)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_oe
    assign io_oe_o[k] = drive && (32'(k) < 32'(lanes));
  end

  assert_sck_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_n_o |-> !sck_o);

  assert_out_hold_high_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sck_o && $past(sck_o)) |-> $stable(io_out_o));

  assert_rx_released_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_valid_o |-> (io_oe_o == 4'b0000));

endmodule

// File: tb/qspi_phase_seq_tb_top.sv
module qspi_phase_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 40;
  localparam int MAXS = 400;
  localparam int NV   = 6;

  typedef struct packed {
    logic [15:0] cfg;
    logic [7:0]  len_m1;
    logic [3:0]  cnt_m1;
    logic [3:0]  tdiv;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'h3108, 8'd1, 4'd0, 4'd1, 1'b0},
    '{16'h411D, 8'd3, 4'd1, 4'd2, 1'b1},
    '{16'h310A, 8'd2, 4'd2, 4'd3, 1'b1},
    '{16'h511E, 8'd4, 4'd0, 4'd1, 1'b0},
    '{16'h4129, 8'd0, 4'd0, 4'd2, 1'b0},
    '{16'h020B, 8'd0, 4'd3, 4'd1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] cfg;
  logic [15:0] len;
  logic [7:0]  cnt;
  logic        tick;
  logic [7:0]  txd;
  logic        txv;
  logic        txr;
  logic [7:0]  rxd;
  logic        rxv;
  logic [3:0]  io_out, io_oe, io_in;
  logic        sck, cs_n, done;

  qspi_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg),
    .pkt_len_m1_i(len), .pkt_cnt_m1_i(cnt), .sck_tick_i(tick),
    .tx_data_i(txd), .tx_valid_i(txv), .tx_ready_o(txr),
    .rx_data_o(rxd), .rx_valid_o(rxv), .io_out_o(io_out), .io_oe_o(io_oe),
    .io_in_i(io_in), .sck_o(sck), .cs_n_o(cs_n), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] txb [MAXB];
  logic [7:0] rxb [MAXB];
  logic [3:0] e_oe [MAXS];
  logic [3:0] e_bits [MAXS];
  logic [3:0] r_in [MAXS];
  int ntx, nrx, ns, nrs;
  int tx_idx, rise_cnt, rx_rise, rx_got, rx_err, slot_err, done_cnt, done_bad, csl_cnt;
  int first_at;
  logic [3:0] first_act, first_exp;
  int tdiv = 1;
  bit stall = 1'b0, sck_prev = 1'b0, pending = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_slots(input logic [7:0] b, input int w, input logic [3:0] m, input bit is_rx);
    for (int s = 0; s < 8 / w; s++) begin
      int v;
      v = (int'(b) >> (8 - w * (s + 1))) & ((1 << w) - 1);
      if (is_rx) begin
        e_oe[ns]   = 4'h0;
        e_bits[ns] = 4'h0;
        r_in[nrs]  = (w == 1) ? 4'(v << 1) : 4'(v);
        nrs++;
      end else begin
        e_oe[ns]   = m;
        e_bits[ns] = 4'(v);
      end
      ns++;
    end
  endtask

  task automatic build(input vec_t v, input int seed);
    int wd, wa, nd;
    logic [7:0] b;
    wd = (v.cfg[1:0] == 2'd0) ? 1 : (v.cfg[1:0] == 2'd1) ? 2 : 4;
    wa = v.cfg[4] ? 1 : wd;
    nd = (int'(v.len_m1) + 1) * (int'(v.cnt_m1) + 1);
    ntx = 0; nrx = 0; ns = 0; nrs = 0;
    for (int i = 0; i < int'(v.cfg[11:8]); i++) begin
      b = 8'((seed * 37 + ntx * 13 + 5) & 255);
      txb[ntx] = b; ntx++;
      add_slots(b, 1, 4'b0001, 1'b0);
    end
    for (int i = 0; i < int'(v.cfg[15:12]); i++) begin
      b = 8'((seed * 37 + ntx * 13 + 5) & 255);
      txb[ntx] = b; ntx++;
      add_slots(b, wa, 4'((1 << wa) - 1), 1'b0);
    end
    if (!v.cfg[5]) begin
      for (int i = 0; i < nd; i++) begin
        if (v.cfg[2]) begin
          b = 8'((seed * 91 + i * 29 + 3) & 255);
          rxb[nrx] = b; nrx++;
          add_slots(b, wd, 4'h0, 1'b1);
        end else begin
          b = 8'((seed * 37 + ntx * 13 + 5) & 255);
          txb[ntx] = b; ntx++;
          add_slots(b, wd, 4'((1 << wd) - 1), 1'b0);
        end
      end
    end
  endtask

  // serial-side model: tick, stream supply, slot comparison, receive drive
  always @(negedge clk) begin
    cyc++;
    if (pending) tx_idx++;
    txv  = !(stall && (cyc % 3 == 0));
    tick = ((cyc % tdiv) == 0);
    if (!cs_n) csl_cnt++;
    if (sck && !sck_prev) begin
      if (rise_cnt < ns) begin
        if (io_oe != e_oe[rise_cnt] || (io_out & io_oe) != e_bits[rise_cnt] || cs_n) begin
          if (slot_err == 0) begin
            first_at  = rise_cnt;
            first_act = io_out & io_oe;
            first_exp = e_bits[rise_cnt];
          end
          slot_err++;
        end
      end
      if (io_oe == 4'h0) rx_rise++;
      rise_cnt++;
    end
    io_in = (rx_rise < nrs) ? r_in[rx_rise] : 4'h0;
    txd   = (tx_idx < ntx) ? txb[tx_idx] : 8'h00;
    pending = txr && txv;
    if (rxv) begin
      if (rx_got >= nrx || rxd != rxb[rx_got]) rx_err++;
      rx_got++;
    end
    if (done) begin
      done_cnt++;
      if (sck || !cs_n || (ns > 0 && !sck_prev)) done_bad++;
    end
    sck_prev = sck;
  end

  task automatic wait_pos();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic clear_mon();
    tx_idx = 0; rise_cnt = 0; rx_rise = 0; rx_got = 0; rx_err = 0;
    slot_err = 0; done_cnt = 0; done_bad = 0; csl_cnt = 0; first_at = -1;
    first_act = 4'h0; first_exp = 4'h0; pending = 1'b0;
  endtask

  task automatic run_op(input vec_t v, input int seed, input bit poke, input string tag);
    build(v, seed);
    wait_pos();
    clear_mon();
    tdiv = int'(v.tdiv); stall = v.stall;
    cfg = v.cfg; len = 16'(v.len_m1); cnt = 8'(v.cnt_m1);
    start = 1'b1;
    wait_pos();
    start = 1'b0;
    for (int k = 0; k < 20000 && done_cnt == 0; k++) begin
      wait_pos();
      if (poke && k == 30) begin start = 1'b1; cfg = 16'hFFFF; len = 16'd0; end
      else if (poke && k == 31) start = 1'b0;
    end
    repeat (20) wait_pos();
    // R11: a single done pulse right after the final falling clock edge
    chk(done_cnt == 1 && done_bad == 0, {"R11 done pulse ", tag}, done_cnt * 10 + done_bad, 10);
    // R2 R3 R4 R8: number of serial clock slots on the wire
    chk(rise_cnt == ns, {"R2 R3 R8 slot count ", tag}, rise_cnt, ns);
    // R2 R3 R4: lane values and enables in every slot
    if (slot_err != 0)
      chk(1'b0, $sformatf("R4 R2 R3 lane bits %s slot %0d", tag, first_at), int'(first_act), int'(first_exp));
    else
      chk(1'b1, "R4", 0, 0);
    // R6 R10: every transmit byte consumed exactly once
    chk(tx_idx == ntx, {"R6 R10 tx bytes taken ", tag}, tx_idx, ntx);
    if (v.cfg[2] && !v.cfg[5]) begin
      // R5: receive bytes assembled and strobed in order
      chk(rx_got == nrx && rx_err == 0, {"R5 rx bytes ", tag}, rx_got * 100 + rx_err, nrx * 100);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg = 16'h0; len = 16'h0; cnt = 8'h0;
    tick = 1'b0; txd = 8'h0; txv = 1'b0; io_in = 4'h0;
    clear_mon();
    ntx = 0; nrx = 0; ns = 0; nrs = 0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk(cs_n && !sck && io_oe == 4'h0 && !done && !txr, "R1 in reset",
        int'({cs_n, sck, done, txr}), 8);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(cs_n && !sck && io_oe == 4'h0 && !done && !txr, "R1 after release",
        int'({cs_n, sck, done, txr}), 8);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i], i + 1, 1'b0, $sformatf("vec%0d", i));
    end

    // R12: start and configuration changes while busy are ignored
    run_op(VECS[2], 9, 1'b1, "busy start");
    chk(csl_cnt > 0 && done_cnt == 1, "R12 no second operation", done_cnt, 1);

    // R7 R11: empty no-data operation finishes without clock edges
    run_op('{16'h0028, 8'd0, 4'd0, 4'd1, 1'b0}, 11, 1'b0, "empty");
    chk(rise_cnt == 0, "R7 R11 empty op clock edges", rise_cnt, 0);

    // R13: starts with half-duplex enable clear or reserved bits set are ignored
    for (int j = 0; j < 2; j++) begin
      wait_pos();
      clear_mon();
      cfg = (j == 0) ? 16'h3100 : 16'h31C8;
      start = 1'b1;
      wait_pos();
      start = 1'b0;
      repeat (40) wait_pos();
      chk(csl_cnt == 0 && done_cnt == 0 && rise_cnt == 0,
          $sformatf("R13 rejected start %0d", j), csl_cnt + done_cnt, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule